// File: doc/BRIEF.md
# Self-Checking Substitution Group with Shared Spare

This block is one slice of a fully parallel AES SubBytes stage. It handles four byte lanes with five identical substitution units. Each unit is an 8-bit register followed by a combinational AES S-Box. The fifth unit is a spare, and it lets the slice duplicate one lane per cycle without losing throughput. A pair code picks two neighbouring units. Both units load the same lane byte, and their results are compared. The remaining lanes are steered around the pair, so all four substituted bytes stay correct in every cycle.

An external scheduler walks the pair code through its four values, so every unit is compared against a neighbour within a few cycles. The block reports the comparison as a mismatch vector aligned with the output bytes. Any response to a mismatch belongs to the surrounding logic. A per-unit fault input flips bit 0 of the byte captured into that unit. Verification uses it to model a defective unit.

Top module: `sbox_spare_group`

## Requirements
- R1: Each lane output is the AES S-Box of its byte. That is the GF(2^8) inverse under modulus 0x11B (with 0 mapped to 0), followed by the affine map b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63. Examples: 0x00 gives 0x63, 0x01 gives 0x7C, 0x53 gives 0xED.
- R2: Outputs show the lane bytes, pair code and fault bits sampled at the previous rising clock edge. The block has one register stage and no other delay.
- R3: While the synchronous active-high reset is applied, every unit holds 0x00. Every lane output then reads 0x63 and chk_o reads 0.
- R4: Pair code p (0..3) selects units p+1 and p. The steering gives both units the same byte, which is lane p. Units above the pair carry lane u-1, and units below it carry lane u.
- R5: With no fault injected, all four lane outputs are correct for every pair code.
- R6: chk_o has at most one bit set, and only bit p of the pair code that was registered with the data.
- R7: chk_o bit p is 1 exactly when the two units of pair p hold different bytes. So a fault in just one of them is flagged. A fault in both, or a fault in a unit outside the pair, gives 0.
- R8: Lane k is taken from unit k when k <= p and from unit k+1 otherwise. A fault in the shadow unit p+1 therefore leaves all lane outputs correct. A fault in a unit that drives lane k changes lane k to the S-Box of its byte with bit 0 inverted.
- R9: fault_i bit u flips bit 0 of the byte captured into unit u. It is registered at the same edge as the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lane_i | input | 32 | Four lane bytes, lane k at bits 8k+7:8k |
| pair_i | input | 2 | Pair code p, units p+1 and p compared |
| fault_i | input | 5 | Per-unit fault injection, bit u flips bit 0 of unit u |
| lane_o | output | 32 | Four substituted bytes, lane k at bits 8k+7:8k |
| chk_o | output | 4 | Mismatch flag, bit p for pair p |

## Verification
Two functions share every cycle: normal substitution of all four lanes, and the duplicate comparison of the active pair. A fault in one unit must show in the right place for each. It appears in chk_o only when that unit is in the pair. It appears in a lane output only when that unit feeds the lane. The bench sweeps every pair code against a fault in each unit, with no fault, and with both pair units faulted. It then runs random mixes. Every cycle is compared against a behavioural model that states separately which unit feeds each lane, and judges both outputs together.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t AFFINE_C = 8'h63;

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return acc;
  endfunction

  // x^254 equals the inverse, and 0 stays 0
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (i != 0) r = gf_mul(r, a);
    end
    return r;
  endfunction

  function automatic byte_t sbox_f(input byte_t a);
    byte_t v;
    byte_t s;
    v = gf_inv(a);
    for (int i = 0; i < 8; i++) begin
      s[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8] ^ v[(i + 6) % 8]
           ^ v[(i + 7) % 8] ^ AFFINE_C[i];
    end
    return s;
  endfunction

endpackage

// File: rtl/sbg_unit.sv
module sbg_unit
  import sbg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  byte_t d_i,
  input  logic  flip_i,
  output byte_t y_o
);
  byte_t q;
  byte_t d_eff;

  assign d_eff = d_i ^ {7'b0, flip_i};

  always_ff @(posedge clk) begin
    if (rst) q <= 8'h00;
    else     q <= d_eff;
  end

  assign y_o = sbox_f(q);

  // R9: the stored byte is the previous input with the flip applied
  assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q == ($past(d_i) ^ {7'b0, $past(flip_i)})));

endmodule

// File: rtl/sbg_steer.sv
module sbg_steer
  import sbg_pkg::*;
#(
  parameter int LANES = 4,
  localparam int UNITS = LANES + 1,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][7:0] lanes_i,
  input  logic [SEL_W-1:0]      pair_i,
  output logic [UNITS-1:0][7:0] unit_d_o
);
  for (genvar u = 0; u < UNITS; u++) begin : g_in
    if (u == 0) begin : g_bottom
      assign unit_d_o[u] = lanes_i[0];
    end else if (u == LANES) begin : g_top
      assign unit_d_o[u] = lanes_i[LANES-1];
    end else begin : g_mid
      assign unit_d_o[u] = (u > int'(pair_i)) ? lanes_i[u-1] : lanes_i[u];
    end
  end
endmodule

// File: rtl/sbg_merge.sv
module sbg_merge
  import sbg_pkg::*;
#(
  parameter int LANES = 4,
  localparam int UNITS = LANES + 1,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [UNITS-1:0][7:0] unit_y_i,
  input  logic [SEL_W-1:0]      pair_q_i,
  output logic [LANES-1:0][7:0] lanes_o,
  output logic [LANES-1:0]      chk_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign lanes_o[k] = (k <= int'(pair_q_i)) ? unit_y_i[k] : unit_y_i[k+1];
    assign chk_o[k]   = (int'(pair_q_i) == k) && (unit_y_i[k+1] != unit_y_i[k]);
  end
endmodule

// File: rtl/sbox_spare_group.sv
module sbox_spare_group
  import sbg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*8-1:0]     lane_i,
  input  logic [$clog2(LANES)-1:0] pair_i,
  input  logic [LANES:0]         fault_i,
  output logic [LANES*8-1:0]     lane_o,
  output logic [LANES-1:0]       chk_o
);
  localparam int UNITS = LANES + 1;
  localparam int SEL_W = $clog2(LANES);

  logic [LANES-1:0][7:0] lanes_in;
  logic [LANES-1:0][7:0] lanes_out;
  logic [UNITS-1:0][7:0] unit_d;
  logic [UNITS-1:0][7:0] unit_y;
  logic [SEL_W-1:0]      pair_q;
  logic                  primed_q;

  assign lanes_in = lane_i;
  assign lane_o   = lanes_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      pair_q   <= pair_i;
      primed_q <= 1'b1;
    end
  end

  sbg_steer #(.LANES(LANES)) u_steer (
    .lanes_i  (lanes_in),
    .pair_i   (pair_i),
    .unit_d_o (unit_d)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    sbg_unit u_unit (
      .clk    (clk),
      .rst    (rst),
      .d_i    (unit_d[u]),
      .flip_i (fault_i[u]),
      .y_o    (unit_y[u])
    );
  end

  sbg_merge #(.LANES(LANES)) u_merge (
    .unit_y_i (unit_y),
    .pair_q_i (pair_q),
    .lanes_o  (lanes_out),
    .chk_o    (chk_o)
  );

  // R4: both units of the selected pair receive the same byte
  assert_pair_same_R4: assert property (@(posedge clk) disable iff (rst)
    unit_d[int'(pair_i) + 1] == unit_d[int'(pair_i)]);

  // R6: at most one mismatch flag at a time
  assert_chk_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_o));

  // R7: no injected fault, no mismatch
  assert_no_false_chk_R7: assert property (@(posedge clk) disable iff (rst)
    (primed_q && ($past(fault_i) == '0)) |-> (chk_o == '0));

  // R5: fault-free lanes carry the S-Box of the previous lane bytes
  for (genvar k = 0; k < LANES; k++) begin : g_chk_lane
    assert_lane_ok_R5: assert property (@(posedge clk) disable iff (rst)
      (primed_q && ($past(fault_i) == '0)) |->
        (lanes_out[k] == sbox_f($past(lane_i[8*k +: 8]))));
  end

endmodule

// File: tb/test_sbox_spare_group.sv
module test_sbox_spare_group;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lane_i;
  logic [1:0]  pair_i;
  logic [4:0]  fault_i;
  logic [31:0] lane_o;
  logic [3:0]  chk_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  tbl [256];
  logic [31:0] exp_lanes;
  logic [3:0]  exp_chk;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbox_spare_group i_sbox_spare_group (
    .clk     (clk),
    .rst     (rst),
    .lane_i  (lane_i),
    .pair_i  (pair_i),
    .fault_i (fault_i),
    .lane_o  (lane_o),
    .chk_o   (chk_o)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod;
    prod = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int bit_i = 14; bit_i >= 8; bit_i--)
      if (prod[bit_i]) prod = prod ^ (16'h011B << (bit_i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_table();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (ref_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      tbl[x] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    end
  endtask

  task automatic compare(input string tag);
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (lane_o[8*k +: 8] !== exp_lanes[8*k +: 8]) begin
        failures++;
        $display("FAIL %s lane %0d: actual %02h expected %02h", tag, k,
                 lane_o[8*k +: 8], exp_lanes[8*k +: 8]);
      end
    end
    checks++;
    if (chk_o !== exp_chk) begin
      failures++;
      $display("FAIL %s chk: actual %b expected %b", tag, chk_o, exp_chk);
    end
  endtask

  // Model: lane k is fed by unit k up to the pair, by unit k+1 above it;
  // the flag fires when exactly one unit of the pair is faulted.
  task automatic cycle(input logic [31:0] lanes, input int p, input logic [4:0] f);
    @(negedge clk);
    compare("R1 R2 R5 R8 lane / R4 R6 R7 R9 flag");
    lane_i  = lanes;
    pair_i  = 2'(p);
    fault_i = f;
    for (int k = 0; k < 4; k++) begin
      int src;
      logic [7:0] b;
      src = (k <= p) ? k : k + 1;
      b = lanes[8*k +: 8];
      if (f[src]) b = b ^ 8'h01;
      exp_lanes[8*k +: 8] = tbl[b];
    end
    exp_chk = (f[p] ^ f[p+1]) ? 4'(1 << p) : 4'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    build_table();
    rst = 1'b1; lane_i = 32'h5A5A_5A5A; pair_i = 2'd2; fault_i = 5'b10101;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_lanes = {4{8'h63}};
    exp_chk = 4'b0;
    compare("R3 reset");
    rst = 1'b0;
    lane_i = 32'h0; pair_i = 2'd0; fault_i = 5'b0;
    exp_lanes = {4{8'h63}};
    exp_chk = 4'b0;
    // R1: known S-Box values 00->63, 01->7C, 53->ED
    cycle(32'hFF53_0100, 0, 5'b0);
    cycle(32'h0053_01FF, 3, 5'b0);
    // R7 R8: every pair code against each single fault, none, and a double fault in the pair
    for (int p = 0; p < 4; p++) begin
      for (int u = -1; u < 5; u++) begin
        cycle(32'h1F2E_3D4C + 32'(p * 77 + u * 13), p,
              (u < 0) ? 5'b0 : 5'(1 << u));
      end
      cycle(32'hC0DE_BEEF, p, 5'(3 << p));
    end
    // R2 R5 R6: random mixes
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [4:0] f;
      r = int'($urandom_range(0, 3));
      f = 5'b0;
      if ((n % 3) == 1) f = 5'(1 << $urandom_range(0, 4));
      if ((n % 7) == 5) f = 5'($urandom);
      cycle($urandom, r, f);
    end
    @(negedge clk);
    compare("R2 R5 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule